// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-allocate cache of one-word lines organised as sets of two ways. A requester presents a byte address with a valid/ready handshake. One cycle after acceptance the block reports a hit together with the stored word, or it reports a miss. The lowest two address bits select a byte inside the word, so they play no part in the lookup. The bits just above them pick the set. The remaining upper bits form the tag, which is compared against both ways of the set at the same time.

On a miss the block raises a request to the next memory level carrying the word address. It then waits as long as needed for a one-cycle response pulse. In the cycle of that pulse the returned word is written into the chosen way and forwarded to the requester as read data. An invalid way is filled first. When both ways are valid, the way that the set's recency bit marks as least recently referenced is overwritten. Every hit and every fill updates that bit. The set count, the address width and the word width are parameters. The set count must be a power of two and at least two.

Top module: `cache2w_top`

## Requirements
- R1: While reset is asserted, and until the first idle cycle after release, `req_ready`, `rsp_valid` and `mem_req_valid` are low. Reset clears every valid bit, so the first access to any block misses.
- R2: The set is the word address (`req_addr[ADDR_W-1:2]`) modulo the set count, which is `req_addr[2 +: log2(SETS)]`. Addresses that differ only in `req_addr[1:0]` reach the same word and hit alike.
- R3: The tag is `req_addr[ADDR_W-1 : 2+log2(SETS)]`. Two blocks with the same set index and different tags never hit on each other's line.
- R4: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low until that request completes. In the cycle after acceptance, either `rsp_valid` with `rsp_hit` or `rsp_miss` is high.
- R5: On a hit, `rsp_valid` and `rsp_hit` are high and `rsp_data` is the word held in the matching way. In a miss-report cycle, `rsp_valid` is low and `rsp_data` is zero.
- R6: After a miss, `mem_req_valid` goes high in the next cycle with `mem_req_addr` set to the word address. Both hold steady until a cycle with `mem_rsp_valid` high.
- R7: In the cycle where `mem_rsp_valid` is high, `rsp_valid` is high, `rsp_hit` is low and `rsp_data` equals `mem_rsp_data`. The word is installed, so a later access to it hits.
- R8: A miss fills an invalid way of the set before it evicts a valid one. At most one way ever matches a lookup.
- R9: When both ways are valid, a miss replaces the way referenced least recently, where both hits and fills count as references.
- R10: With two sets, alternating references to word 0 and word 4 miss twice and then hit on every later access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | ADDR_W | Byte address of the lookup |
| rsp_valid | output | 1 | Read data valid (hit or refill) |
| rsp_hit | output | 1 | Read data came from a hit |
| rsp_miss | output | 1 | Lookup missed; refill follows |
| rsp_data | output | DATA_W | Read word |
| mem_req_valid | output | 1 | Refill request to memory |
| mem_req_addr | output | ADDR_W-2 | Word address to refill |
| mem_rsp_valid | input | 1 | One-cycle refill response pulse |
| mem_rsp_data | input | DATA_W | Refill word |

## Verification
The bench drives the two-block ping-pong in one set. A design that ignores the empty way, or that evicts the line it just filled, keeps missing instead of settling into hits. It then walks eviction orders in which a hit alone must change the victim. A design that updates recency only on fills, or that inverts the recency bit, evicts the wrong block, and the next access to that block misses where it should hit. Byte-offset variants, same-set tag conflicts and a tag of all ones catch indexing and tag slices cut at the wrong bit. Refill responses come after zero to three stall cycles, which exposes a request that drops early, an address that drifts during the wait, or read data that leaks out during a miss report.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_LOOK = 2'd2,
    ST_FILL = 2'd3
  } ctrl_state_e;

  // Victim choice: an empty way wins (way 0 first), otherwise the
  // least recently referenced way recorded for the set.
  function automatic logic pick_victim(input logic [WAYS-1:0] way_valid,
                                       input logic            stale_way);
    if (!way_valid[0]) return 1'b0;
    if (!way_valid[1]) return 1'b1;
    return stale_way;
  endfunction

endpackage

// File: rtl/cache2w_rst_sync.sv
module cache2w_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/cache2w_way_store.sv
module cache2w_way_store #(
  parameter int SETS   = 2,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [SETS-1:0]   valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // Tag and payload arrays carry no reset; the valid bit guards them.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/cache2w_tag_cmp.sv
module cache2w_tag_cmp #(
  parameter int TAG_W = 5
) (
  input  logic             entry_valid,
  input  logic [TAG_W-1:0] entry_tag,
  input  logic [TAG_W-1:0] look_tag,
  output logic             match
);

  assign match = entry_valid && (entry_tag == look_tag);

endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SETS = 2,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [IDX_W-1:0]             idx,
  input  logic [cache2w_pkg::WAYS-1:0] way_valid,
  input  logic                         upd_en,
  input  logic                         upd_way,
  output logic                         victim
);

  import cache2w_pkg::*;

  // One bit per set naming the way referenced least recently.
  logic [SETS-1:0] stale_q, stale_d;

  always_comb begin
    stale_d = stale_q;
    if (upd_en) stale_d[idx] = ~upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stale_q <= '0;
    else        stale_q <= stale_d;
  end

  assign victim = pick_victim(way_valid, stale_q[idx]);

endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic hit_any,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic accept,
  output logic look_active,
  output logic fill_active,
  output logic fill_done
);

  import cache2w_pkg::*;

  ctrl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT: state_d = ST_IDLE;
      ST_IDLE: if (req_valid) state_d = ST_LOOK;
      ST_LOOK: state_d = hit_any ? ST_IDLE : ST_FILL;
      ST_FILL: if (mem_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_ready && req_valid;
  assign look_active = (state_q == ST_LOOK);
  assign fill_active = (state_q == ST_FILL);
  assign fill_done   = fill_active && mem_rsp_valid;

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [ADDR_W-3:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  import cache2w_pkg::*;

  localparam int OFF_W   = 2;
  localparam int WADDR_W = ADDR_W - OFF_W;
  localparam int IDX_W   = $clog2(SETS);
  localparam int TAG_W   = WADDR_W - IDX_W;

  logic rst_int_n;
  logic accept, look_active, fill_active, fill_done;
  logic hit_any, victim, lru_upd_en, lru_upd_way;

  logic [WADDR_W-1:0] waddr_q, waddr_d;
  logic [IDX_W-1:0]   look_idx;
  logic [TAG_W-1:0]   look_tag;

  logic [WAYS-1:0]   hit_way;
  logic [WAYS-1:0]   way_valid;
  logic [WAYS-1:0]   way_wr;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [DATA_W-1:0] way_data [WAYS];
  logic [DATA_W-1:0] hit_data;

  logic unused_byte_off;
  assign unused_byte_off = ^req_addr[OFF_W-1:0];

  cache2w_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cache2w_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .req_valid     (req_valid),
    .hit_any       (hit_any),
    .mem_rsp_valid (mem_rsp_valid),
    .req_ready     (req_ready),
    .accept        (accept),
    .look_active   (look_active),
    .fill_active   (fill_active),
    .fill_done     (fill_done)
  );

  // Captured word address, loaded only when a request is taken.
  always_comb begin
    waddr_d = waddr_q;
    if (accept) waddr_d = req_addr[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) waddr_q <= '0;
    else            waddr_q <= waddr_d;
  end

  assign look_idx = waddr_q[IDX_W-1:0];
  assign look_tag = waddr_q[WADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache2w_way_store #(
      .SETS   (SETS),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_store (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .rd_idx   (look_idx),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_data  (way_data[w]),
      .wr_en    (way_wr[w]),
      .wr_idx   (look_idx),
      .wr_tag   (look_tag),
      .wr_data  (mem_rsp_data)
    );

    cache2w_tag_cmp #(
      .TAG_W (TAG_W)
    ) u_cmp (
      .entry_valid (way_valid[w]),
      .entry_tag   (way_tag[w]),
      .look_tag    (look_tag),
      .match       (hit_way[w])
    );

    assign way_wr[w] = fill_done && (victim == 1'(w));
  end

  assign hit_any = |hit_way;

  // AND-OR way select driven by the per-way hit decisions.
  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_way[w]) hit_data = hit_data | way_data[w];
    end
  end

  assign lru_upd_en  = (look_active && hit_any) || fill_done;
  assign lru_upd_way = fill_done ? victim : hit_way[1];

  cache2w_lru #(
    .SETS (SETS)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .idx       (look_idx),
    .way_valid (way_valid),
    .upd_en    (lru_upd_en),
    .upd_way   (lru_upd_way),
    .victim    (victim)
  );

  assign rsp_hit       = look_active && hit_any;
  assign rsp_miss      = look_active && !hit_any;
  assign rsp_valid     = rsp_hit || fill_done;
  assign rsp_data      = fill_done ? mem_rsp_data : (rsp_hit ? hit_data : '0);
  assign mem_req_valid = fill_active;
  assign mem_req_addr  = waddr_q;

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_req_valid,
  input logic [ADDR_W-3:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data,
  input logic [1:0]        hit_way
);

  logic [ADDR_W-3:0] seen_waddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_waddr <= '0;
    else if (req_valid && req_ready) seen_waddr <= req_addr[ADDR_W-1:2];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!req_ready && !rsp_valid && !mem_req_valid);
    end
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_result_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ((rsp_valid && rsp_hit) || rsp_miss));

  assert_hit_is_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  assert_miss_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_valid && rsp_data == '0));

  assert_miss_requests_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |=> mem_req_valid);

  assert_fill_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr == seen_waddr));

  assert_fill_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_refill_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid) |-> (rsp_valid && !rsp_hit && rsp_data == mem_rsp_data));

  assert_single_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_way));

endmodule

bind cache2w_top cache2w_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_miss      (rsp_miss),
  .rsp_data      (rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_data  (mem_rsp_data),
  .hit_way       (hit_way)
);

// File: tb/cache2w_tb_top.sv
module cache2w_tb_top;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SETS   = 2;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic              rsp_hit;
  logic              rsp_miss;
  logic [DATA_W-1:0] rsp_data;
  logic              mem_req_valid;
  logic [ADDR_W-3:0] mem_req_addr;
  logic              mem_rsp_valid;
  logic [DATA_W-1:0] mem_rsp_data;

  int n_checks = 0;
  int n_fail   = 0;

  bit          exp_hit_q [$];
  logic [31:0] exp_data_q[$];
  string       exp_tag_q [$];

  cache2w_top #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SETS   (SETS)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_miss      (rsp_miss),
    .rsp_data      (rsp_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] mem_word(input int waddr);
    return 32'hC0DE_0000 + 32'(waddr) * 32'h0001_0003;
  endfunction

  task automatic check(input bit ok, input string rq,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  // Driver: queue the expected result, issue the lookup, serve any refill.
  task automatic access(input logic [ADDR_W-1:0] addr, input bit exp_hit,
                        input int lat, input string rq);
    int waddr;
    waddr = int'(addr >> 2);
    exp_hit_q.push_back(exp_hit);
    exp_data_q.push_back(mem_word(waddr));
    exp_tag_q.push_back(rq);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(rsp_miss == !exp_hit, rq, 32'(rsp_miss), 32'(!exp_hit));
    check(!req_ready, "R4", 32'(req_ready), 32'd0);
    if (!exp_hit) begin
      check(!rsp_valid && rsp_data == '0, "R5", rsp_data, 32'd0);
      @(negedge clk);
      #1;
      check(mem_req_valid && mem_req_addr == addr[ADDR_W-1:2], "R6",
            32'(mem_req_addr), 32'(addr[ADDR_W-1:2]));
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        #1;
        check(mem_req_valid && mem_req_addr == addr[ADDR_W-1:2], "R6",
              32'(mem_req_addr), 32'(addr[ADDR_W-1:2]));
      end
      @(negedge clk);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(waddr);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
    end
  endtask

  // Monitor: every rsp_valid pops one expected item.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rsp_valid) begin
        if (exp_hit_q.size() == 0) begin
          check(1'b0, "R4", 32'd1, 32'd0);
        end else begin
          bit          eh;
          logic [31:0] ed;
          string       et;
          eh = exp_hit_q.pop_front();
          ed = exp_data_q.pop_front();
          et = exp_tag_q.pop_front();
          check(rsp_hit == eh, et, 32'(rsp_hit), 32'(eh));
          check(rsp_data == ed, eh ? "R5" : "R7", rsp_data, ed);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    rst_n         = 1'b0;
    req_valid     = 1'b0;
    req_addr      = '0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!req_ready && !rsp_valid && !mem_req_valid, "R1",
          {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    #1;
    check(req_ready && !mem_req_valid, "R1", 32'(req_ready), 32'd1);

    // R10 / R8: ping-pong between word 0 and word 4, both in set 0.
    access(8'h00, 1'b0, 0, "R1");
    access(8'h10, 1'b0, 1, "R8");
    for (int i = 0; i < 3; i++) begin
      access(8'h00, 1'b1, 0, "R10");
      access(8'h10, 1'b1, 0, "R10");
    end

    // R2: byte offset is ignored; word 0 is now most recent in set 0.
    access(8'h03, 1'b1, 0, "R2");
    // R2: set 1 is separate from set 0.
    access(8'h04, 1'b0, 2, "R2");
    access(8'h06, 1'b1, 0, "R2");
    access(8'h01, 1'b1, 0, "R2");

    // R9: set 0 holds w0 (recent) and w4 (stale).
    access(8'h20, 1'b0, 0, "R9");  // w8 evicts w4
    access(8'h00, 1'b1, 0, "R9");
    access(8'h20, 1'b1, 0, "R9");
    access(8'h10, 1'b0, 3, "R9");  // w4 evicts w0
    access(8'h00, 1'b0, 0, "R9");  // w0 evicts w8
    access(8'h10, 1'b1, 0, "R9");
    access(8'h02, 1'b1, 0, "R9");
    access(8'h20, 1'b0, 1, "R9");  // w8 evicts w4

    // R3: all-ones tag in set 1, same index as w1.
    access(8'hFC, 1'b0, 0, "R3");
    access(8'hFD, 1'b1, 0, "R3");
    access(8'h04, 1'b1, 0, "R3");  // w1 recent, w63 stale
    access(8'h0C, 1'b0, 2, "R9");  // w3 evicts w63
    access(8'h04, 1'b1, 0, "R9");
    access(8'hFC, 1'b0, 0, "R3");  // w63 evicts w3
    access(8'h0C, 1'b0, 0, "R7");  // w3 evicts w1
    access(8'h0C, 1'b1, 0, "R7");

    repeat (4) @(negedge clk);
    check(exp_hit_q.size() == 0, "R4", 32'(exp_hit_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule